// File: doc/BRIEF.md
# Management Interface Register Responder

This block answers management frames on a two-wire serial interface and plays the part of the PHY. The management clock, the master's data bit and the master's drive-enable are sampled with the system clock. A rising management-clock edge is found by comparing the clock's level with the level stored in the previous system cycle. On each such edge one bit goes into a 32-bit history. A run of 32 one bits marks the start of a frame. A down-counter then places each frame field, and the header is decoded once its 16 bits have arrived.

Read frames are answered from a 32-entry table of 16-bit values. The bits go out on the data-out pin, MSB first. Two entries hold fixed identifier values and all other entries read as zero. Write frames are decoded and run to their end, but their data is dropped. The PHY address field is decoded but does not select anything: every address gets the same table.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, `mdio_di_o` is 0 and the block is idle. A frame needs a new preamble before it is accepted.
- R2: A sampled bit is 1 only when both `mdio_do_i` and `mdio_oe_i` are high at the rising edge of `mdc_i`. Ones driven with `mdio_oe_i` low count as zeros and cannot form a preamble.
- R3: The block synchronises when the last 32 sampled bits are all 1. The preamble may be longer than 32 bits. A run of 31 ones is not enough, and a frame sent without a new preamble is ignored.
- R4: The header is the 16 bits sampled after the last preamble bit, oldest first: start (2 bits), opcode (2 bits), PHY address (5 bits), register address (5 bits), turnaround (2 bits). It is decoded on the 16th edge after synchronisation.
- R5: A read is accepted only with start 01, opcode 10 and a second turnaround bit of 0. Any other header leaves `mdio_di_o` unchanged for the frame, unless it is a valid write.
- R6: A write frame (start 01, opcode 01, turnaround 10) is consumed to its 16th data bit and then discarded. A later read of the same register returns the default value.
- R7: Register 2 reads 0x0022, register 3 reads 0x161A and every other register reads 0x0000.
- R8: The register returned does not depend on the PHY address field.
- R9: `mdio_di_o` changes only in the system cycle that follows a rising `mdc_i` edge. During a read it presents bit 15 down to bit 0 on edges 17 to 32 after synchronisation, and it holds the last bit afterwards.
- R10: On the 32nd edge after synchronisation, the last data bit goes out and the block returns to idle in the same step. A new preamble may start on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all management signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock level |
| mdio_do_i | input | 1 | Data bit driven by the management master |
| mdio_oe_i | input | 1 | Master drive-enable; qualifies `mdio_do_i` |
| mdio_di_o | output | 1 | Data bit returned to the master during a read |

## Verification
On the 32nd edge after synchronisation, the last data bit shifts out and the frame completes in the same step. The bench sends back-to-back reads: the second preamble follows the first frame's least significant bit with no gap. A behavioural model checks the final bit, and a correct return of the second register shows that the slave went idle and synchronised again at once. A write frame followed at once by a read covers the same completion step for the write state. The model checks that the write left `mdio_di_o` untouched.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int HDR_W  = 16;
  localparam int NREGS  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_t;

  // Header layout, MSB first as the bits arrive.
  typedef struct packed {
    logic [1:0]        start;
    logic [1:0]        op;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [1:0]        ta;
  } mgmt_hdr_t;

  function automatic xfer_state_t classify(input logic [HDR_W-1:0] raw);
    mgmt_hdr_t h;
    h = mgmt_hdr_t'(raw);
    if (h.start == 2'b01 && h.op == 2'b01 && h.ta == 2'b10)
      return ST_WRITE;
    else if (h.start == 2'b01 && h.op == 2'b10 && !h.ta[0])
      return ST_READ;
    else
      return ST_IDLE;
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_regad(input logic [HDR_W-1:0] raw);
    mgmt_hdr_t h;
    h = mgmt_hdr_t'(raw);
    return h.regad;
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] idx_a,
    input logic [DATA_W-1:0] val_a,
    input logic [ADDR_W-1:0] idx_b,
    input logic [DATA_W-1:0] val_b
  );
    if (a == idx_a)      return val_a;
    else if (a == idx_b) return val_b;
    else                 return '0;
  endfunction
endpackage

// File: rtl/mdio_edge_sampler.sv
module mdio_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdo_i,
  input  logic mdoe_i,
  output logic edge_o,
  output logic bit_o
);
  logic mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_i;
  end

  assign edge_o = mdc_i & ~mdc_q;
  assign bit_o  = mdo_i & mdoe_i;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_slv_pkg::*;
#(
  parameter int unsigned SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_i,
  input  logic              bit_i,
  output logic              rd_load_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              shift_o,
  output logic              wr_done_o
);
  localparam int CNT_W = $clog2(SYNC_W + 1);

  logic [SYNC_W-1:0] shreg, shreg_nx;
  logic [CNT_W-1:0]  cnt, cnt_eff;
  xfer_state_t       state, state_mid, state_nx, dec_state;
  logic              sync_hit, dec_hit, fin;

  always_comb begin
    shreg_nx  = {shreg[SYNC_W-2:0], bit_i};
    sync_hit  = edge_i && (&shreg_nx);
    cnt_eff   = sync_hit ? CNT_W'(SYNC_W) : cnt;
    dec_hit   = edge_i && (cnt_eff == CNT_W'(HDR_W));
    dec_state = classify(shreg_nx[HDR_W-1:0]);
    state_mid = dec_hit ? dec_state : state;
    rd_load_o = dec_hit && (dec_state == ST_READ);
    rd_addr_o = hdr_regad(shreg_nx[HDR_W-1:0]);
    shift_o   = edge_i && (cnt_eff < CNT_W'(HDR_W)) && (state_mid == ST_READ);
    fin       = edge_i && (cnt_eff == '0) && (state_mid != ST_IDLE);
    wr_done_o = fin && (state_mid == ST_WRITE);
    state_nx  = fin ? ST_IDLE : state_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      state <= ST_IDLE;
    end else if (edge_i) begin
      shreg <= shreg_nx;
      cnt   <= (cnt_eff == '0) ? '0 : cnt_eff - 1'b1;
      state <= state_nx;
    end
  end

  // R3: a detected preamble reloads the counter, then one step is taken
  a_r3_sync_reload: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (cnt == CNT_W'(SYNC_W - 1)));

  // R4: a read starts only on the header edge
  a_r4_read_at_header: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_READ) |-> ($past(cnt) == CNT_W'(HDR_W)));

  // R10: the final edge returns the slave to idle
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (state == ST_IDLE));
endmodule

// File: rtl/mdio_id_rom.sv
module mdio_id_rom
  import mdio_slv_pkg::*;
#(
  parameter logic [ADDR_W-1:0] IDX_A = 5'd2,
  parameter logic [DATA_W-1:0] VAL_A = 16'h0022,
  parameter logic [ADDR_W-1:0] IDX_B = 5'd3,
  parameter logic [DATA_W-1:0] VAL_B = 16'h161A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] table_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    assign table_q[g] = reg_default(ADDR_W'(g), IDX_A, VAL_A, IDX_B, VAL_B);
  end

  assign data_o = table_q[addr_i];
endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter
  import mdio_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              shift_i,
  output logic              di_o
);
  logic [DATA_W-1:0] dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      di_o <= 1'b0;
    end else if (load_i) begin
      dout <= word_i;
    end else if (shift_i) begin
      di_o <= dout[DATA_W-1];
      dout <= {dout[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int unsigned       SYNC_W    = 32,
  parameter logic [ADDR_W-1:0] ID_HI_IDX = 5'd2,
  parameter logic [DATA_W-1:0] ID_HI_VAL = 16'h0022,
  parameter logic [ADDR_W-1:0] ID_LO_IDX = 5'd3,
  parameter logic [DATA_W-1:0] ID_LO_VAL = 16'h161A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_do_i,
  input  logic mdio_oe_i,
  output logic mdio_di_o
);
  logic              mdc_edge, smp_bit;
  logic              rd_load, shift_en, wr_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;

  mdio_edge_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdo_i(mdio_do_i),
    .mdoe_i(mdio_oe_i), .edge_o(mdc_edge), .bit_o(smp_bit)
  );

  mdio_frame_ctrl #(.SYNC_W(SYNC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .edge_i(mdc_edge), .bit_i(smp_bit),
    .rd_load_o(rd_load), .rd_addr_o(rd_addr), .shift_o(shift_en),
    .wr_done_o(wr_done)
  );

  mdio_id_rom #(
    .IDX_A(ID_HI_IDX), .VAL_A(ID_HI_VAL), .IDX_B(ID_LO_IDX), .VAL_B(ID_LO_VAL)
  ) u_rom (
    .addr_i(rd_addr), .data_o(rd_word)
  );

  mdio_read_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(rd_load), .word_i(rd_word),
    .shift_i(shift_en), .di_o(mdio_di_o)
  );

  // R9: output moves only after a management clock edge
  a_r9_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_edge |=> $stable(mdio_di_o));

  // R6: finishing a write leaves the output untouched
  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> $stable(mdio_di_o));

  // R9: a shift and a table fetch never share an edge
  a_r9_no_load_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_load && shift_en));
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0, mdo = 1'b0, moe = 1'b0;
  logic di;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_slave u_dut (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_do_i(mdo),
    .mdio_oe_i(moe), .mdio_di_o(di)
  );

  // ---------------- behavioural reference ----------------
  bit         hist[$];
  int         ones_run = 0;
  int         pos = 1000;
  bit         reading = 0;
  logic [15:0] word = '0;
  logic       exp_di = 1'b0;
  logic       mdc_prev = 1'b0;

  function automatic logic [15:0] exp_reg(int ra);
    case (ra)
      2: return 16'h0022;
      3: return 16'h161A;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_edge(bit b);
    int st, op, ra;
    hist.push_back(b);
    if (hist.size() > 16) void'(hist.pop_front());
    ones_run = b ? ones_run + 1 : 0;
    if (ones_run >= 32) pos = 0;
    else if (pos < 1000) pos++;
    if (pos == 16) begin
      st = hist[0] * 2 + hist[1];
      op = hist[2] * 2 + hist[3];
      ra = 0;
      for (int k = 9; k <= 13; k++) ra = ra * 2 + hist[k];
      reading = (st == 1) && (op == 2) && (hist[15] == 1'b0);
      if (reading) word = exp_reg(ra);
    end
    if (reading && pos >= 17 && pos <= 32) exp_di = word[32 - pos];
    if (pos == 32) reading = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); ones_run = 0; pos = 1000; reading = 0;
      exp_di = 1'b0; mdc_prev = 1'b0;
    end else begin
      if (mdc && !mdc_prev) model_edge(mdo & moe);
      mdc_prev = mdc;
    end
  end

  // R9: cycle-by-cycle comparison of the output pin
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (di !== exp_di) begin
        fails++;
        $display("FAIL R9 per-cycle: time %0t di=%b expected %b", $time, di, exp_di);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input logic oe, output logic smp);
    @(negedge clk);
    mdc = 1'b0; mdo = d; moe = oe;
    repeat (2) @(negedge clk);
    mdc = 1'b1;
    repeat (2) @(negedge clk);
    smp = di;
  endtask

  task automatic send_run(int n, logic d, logic oe);
    logic s;
    for (int i = 0; i < n; i++) send_bit(d, oe, s);
  endtask

  task automatic send_field(int val, int w);
    logic s;
    for (int i = w - 1; i >= 0; i--) send_bit(val[i], 1'b1, s);
  endtask

  task automatic do_read(int pre, int st, int op, int phy, int ra, bit bad_ta,
                         output logic [15:0] got);
    logic s;
    send_run(pre, 1'b1, 1'b1);
    send_field(st, 2); send_field(op, 2); send_field(phy, 5); send_field(ra, 5);
    send_bit(1'b0, 1'b0, s);
    if (bad_ta) send_bit(1'b1, 1'b1, s);
    else        send_bit(1'b0, 1'b0, s);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0, 1'b0, s);
      got[i] = s;
    end
  endtask

  task automatic do_write(int phy, int ra, int data);
    send_run(32, 1'b1, 1'b1);
    send_field(1, 2); send_field(1, 2); send_field(phy, 5); send_field(ra, 5);
    send_field(2, 2); send_field(data, 16);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [15:0] w;
    repeat (4) @(negedge clk);
    check("R1 reset output", {15'd0, di}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {15'd0, di}, 16'h0000);

    do_read(32, 1, 2, 1, 2, 0, w);   check("R4 R7 read reg2", w, 16'h0022);
    do_read(32, 1, 2, 17, 3, 0, w);  check("R8 R7 read reg3 phy17", w, 16'h161A);
    do_read(32, 1, 2, 31, 9, 0, w);  check("R7 read reg9 zero", w, 16'h0000);
    do_write(4, 3, 16'hFFFF);
    check("R6 output after write", {15'd0, di}, 16'h0000);
    do_read(32, 1, 2, 4, 3, 0, w);   check("R6 reg3 unchanged", w, 16'h161A);
    do_read(32, 0, 2, 1, 3, 0, w);   check("R5 bad start ignored", w, 16'h0000);
    do_read(32, 1, 2, 1, 3, 1, w);   check("R5 bad turnaround ignored", w, 16'h0000);
    send_run(32, 1'b1, 1'b0);
    do_read(0, 1, 2, 1, 3, 0, w);    check("R2 undriven preamble", w, 16'h0000);
    do_read(31, 1, 2, 1, 3, 0, w);   check("R3 short preamble", w, 16'h0000);
    do_read(0, 1, 2, 1, 3, 0, w);    check("R3 no preamble", w, 16'h0000);
    do_read(40, 1, 2, 9, 2, 0, w);   check("R3 long preamble", w, 16'h0022);
    do_read(32, 1, 2, 0, 3, 0, w);   check("R10 first back-to-back", w, 16'h161A);
    do_read(32, 1, 2, 0, 2, 0, w);   check("R10 second back-to-back", w, 16'h0022);
    repeat (10) @(negedge clk);
    check("R9 holds last bit", {15'd0, di}, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule